// File: doc/BRIEF.md
# Link Power-Status Activity Detector

This block decides whether the link-layer device attached to a physical-layer chip is awake. It watches a single power-status line driven by the link device, brings that line into the local PHY clock domain, and measures how long each high and low phase lasts. A line held high counts as an active link. A line that toggles also counts as an active link, provided every high and low phase has a length inside a window of allowed durations. A line that stays low, or toggles with a phase that is too short or too long, marks the link as absent. In that case the chip should act only as a repeater.

The start-up sequencer raises `enable` once power-up is complete and isolation is deselected. While `enable` is low, the detector holds both flags low and forgets everything it has measured. The two outputs are mutually exclusive. Both low means no verdict has been reached yet. The window limits are parameters counted in clock cycles. At the default 200 MHz clock, 18 cycles and 200 cycles give 90 ns and 1000 ns.

Top module: `link_presence_detector`

## Requirements
- R1: While `rst_n` or `enable` is low, `link_active` and `repeater_mode` are both 0. After `enable` falls, both flags are 0 at the next rising edge.
- R2: The input passes through `SYNC_STAGES` flip-flops (default 2). A level change that decides a verdict reaches the flags on the third rising edge after the input changes.
- R3: An input held high for more than `MAX_CYC` cycles sets `link_active`=1 and `repeater_mode`=0. A later fall that ends such a long high phase is not a fault.
- R4: An input held low for more than `MAX_CYC` cycles sets `repeater_mode`=1 and `link_active`=0.
- R5: A pulse train whose high and low phases each last between `MIN_CYC` and `MAX_CYC` cycles sets `link_active`. It is set at the rise that ends the first complete valid high phase followed by a valid low phase.
- R6: A high phase shorter than `MIN_CYC` cycles clears `link_active` and sets `repeater_mode`.
- R7: A low phase shorter than `MIN_CYC` cycles clears `link_active` and sets `repeater_mode`.
- R8: Phases of exactly `MIN_CYC` cycles and exactly `MAX_CYC` cycles are valid.
- R9: After `repeater_mode` has been set, a later complete valid high-then-low cycle restores `link_active`.
- R10: The phase already in progress when `enable` rises is counted from that moment. The length of that first phase is never judged as too short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | From the start-up sequencer: power-up is done and isolation is off |
| link_pwr_in | input | 1 | Link power-status line, asynchronous to `clk` |
| link_active | output | 1 | Link-layer device judged active |
| repeater_mode | output | 1 | Link judged absent; operate as repeater only |

## Verification
A verdict taken at a phase edge appears on the flags three rising edges after the bench changes the input. That is two synchronizer edges plus the edge at which the new level meets the stored level. The bench checks one such edge exactly: the flag must still be low after the second edge and high after the third. A verdict on an over-long phase appears `MAX_CYC`+1 edges after the phase became visible. The bench therefore samples these verdicts well before that point and well after it. All other checks are taken on falling edges, at least seven cycles after the deciding input change and before the next one, so a one-cycle shift in latency does not change their outcome.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
   typedef enum logic [1:0] {
      MODE_WAIT = 2'd0,
      MODE_LINK = 2'd1,
      MODE_RPT  = 2'd2
   } lpd_mode_e;
endpackage

// File: rtl/lpd_sync.sv
module lpd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("lpd_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lpd_phase_timer.sv
module lpd_phase_timer #(
   parameter int MAX_CYC = 200,
   parameter int CNT_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             lvl_in,
   output logic             edge_evt,
   output logic             edge_from_high,
   output logic [CNT_W-1:0] edge_len,
   output logic             long_evt,
   output logic             long_high
);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_CYC);

   logic             primed;
   logic             full;
   logic             lvl;
   logic [CNT_W-1:0] cnt;
   logic             chg;

   assign chg            = en && primed && (lvl_in != lvl);
   assign edge_evt       = chg && full;
   assign edge_from_high = lvl;
   assign edge_len       = cnt;
   assign long_evt       = en && primed && !chg && (cnt == CAP);
   assign long_high      = lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed <= 1'b0;
         full   <= 1'b0;
         lvl    <= 1'b0;
         cnt    <= '0;
      end else if (!en) begin
         primed <= 1'b0;
         full   <= 1'b0;
         lvl    <= 1'b0;
         cnt    <= '0;
      end else if (!primed) begin
         primed <= 1'b1;
         lvl    <= lvl_in;
         cnt    <= CNT_W'(1);
      end else if (chg) begin
         full   <= 1'b1;
         lvl    <= lvl_in;
         cnt    <= CNT_W'(1);
      end else if (cnt <= CAP) begin
         cnt    <= cnt + CNT_W'(1);
      end
   end

   // R2
   lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && primed && (lvl_in != lvl)) |=> (lvl == $past(lvl_in)));
endmodule

// File: rtl/lpd_classifier.sv
module lpd_classifier
   import lpd_pkg::*;
#(
   parameter int MIN_CYC = 18,
   parameter int MAX_CYC = 200,
   parameter int CNT_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             edge_evt,
   input  logic             edge_from_high,
   input  logic [CNT_W-1:0] edge_len,
   input  logic             long_evt,
   input  logic             long_high,
   output lpd_mode_e        mode
);
   localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(MIN_CYC);
   localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(MAX_CYC);

   lpd_mode_e mode_nx;
   logic      hi_ok, hi_ok_nx;
   logic      too_short, too_long;

   assign too_short = edge_len < LO_LIM;
   assign too_long  = edge_len > HI_LIM;

   always_comb begin
      mode_nx  = mode;
      hi_ok_nx = hi_ok;
      if (!en) begin
         mode_nx  = MODE_WAIT;
         hi_ok_nx = 1'b0;
      end else if (long_evt) begin
         mode_nx  = long_high ? MODE_LINK : MODE_RPT;
         hi_ok_nx = 1'b0;
      end else if (edge_evt) begin
         if (too_short || (too_long && !edge_from_high)) begin
            mode_nx  = MODE_RPT;
            hi_ok_nx = 1'b0;
         end else if (edge_from_high) begin
            hi_ok_nx = !too_long;
         end else if (hi_ok) begin
            mode_nx  = MODE_LINK;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode  <= MODE_WAIT;
         hi_ok <= 1'b0;
      end else begin
         mode  <= mode_nx;
         hi_ok <= hi_ok_nx;
      end
   end

   // R1
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (mode == MODE_WAIT));
   // R6 R7
   short_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && edge_evt && (edge_len < LO_LIM)) |=> (mode == MODE_RPT));
   // R3
   long_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && long_evt && long_high) |=> (mode == MODE_LINK));
   // R4
   long_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && long_evt && !long_high) |=> (mode == MODE_RPT));
   // R5
   link_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode == MODE_LINK) |->
         $past(long_evt && long_high) || $past(edge_evt && !edge_from_high && hi_ok));
endmodule

// File: rtl/link_presence_detector.sv
module link_presence_detector
   import lpd_pkg::*;
#(
   parameter int MIN_CYC     = 18,
   parameter int MAX_CYC     = 200,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic link_pwr_in,
   output logic link_active,
   output logic repeater_mode
);
   localparam int CNT_W = $clog2(MAX_CYC + 2);

   generate
      if (MIN_CYC < 1) begin : g_bad_min
         $error("link_presence_detector: MIN_CYC must be at least 1");
      end
      if (MAX_CYC < MIN_CYC) begin : g_bad_max
         $error("link_presence_detector: MAX_CYC must not be below MIN_CYC");
      end
   endgenerate

   logic             lvl_s;
   logic             edge_evt, edge_from_high, long_evt, long_high;
   logic [CNT_W-1:0] edge_len;
   lpd_mode_e        mode;

   lpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(link_pwr_in), .q(lvl_s)
   );

   lpd_phase_timer #(.MAX_CYC(MAX_CYC), .CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(enable), .lvl_in(lvl_s),
      .edge_evt(edge_evt), .edge_from_high(edge_from_high), .edge_len(edge_len),
      .long_evt(long_evt), .long_high(long_high)
   );

   lpd_classifier #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .CNT_W(CNT_W)) u_class (
      .clk(clk), .rst_n(rst_n), .en(enable),
      .edge_evt(edge_evt), .edge_from_high(edge_from_high), .edge_len(edge_len),
      .long_evt(long_evt), .long_high(long_high), .mode(mode)
   );

   assign link_active   = (mode == MODE_LINK);
   assign repeater_mode = (mode == MODE_RPT);
endmodule

// File: tb/link_presence_detector_test.sv
`timescale 1ns/1ps
module link_presence_detector_test;
   localparam int MINC = 18;
   localparam int MAXC = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic lps = 1'b0;
   logic link_active, repeater_mode;
   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   link_presence_detector #(.MIN_CYC(MINC), .MAX_CYC(MAXC), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .link_pwr_in(lps),
      .link_active(link_active), .repeater_mode(repeater_mode)
   );

   task automatic check(input logic got, input logic exp, input string req, input string what);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got=%0b expected=%0b", req, what, got, exp);
      end
   endtask

   task automatic flags(input logic la, input logic rm, input string req);
      check(link_active, la, req, "link_active");
      check(repeater_mode, rm, req, "repeater_mode");
   endtask

   task automatic hold(input logic v, input int n);
      lps = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic turn_off();
      enable = 1'b0;
      repeat (2) @(negedge clk);
      flags(1'b0, 1'b0, "R1");
   endtask

   task automatic t_steady_high();
      hold(1'b1, 5);
      enable = 1'b1;
      repeat (150) @(negedge clk);
      flags(1'b0, 1'b0, "R3");
      repeat (100) @(negedge clk);
      flags(1'b1, 1'b0, "R3");
      hold(1'b0, 50);
      flags(1'b1, 1'b0, "R3");
      turn_off();
   endtask

   task automatic t_steady_low();
      hold(1'b0, 5);
      enable = 1'b1;
      repeat (150) @(negedge clk);
      flags(1'b0, 1'b0, "R4");
      repeat (100) @(negedge clk);
      flags(1'b0, 1'b1, "R4");
      turn_off();
   endtask

   task automatic t_train(input int h, input int l, input string req);
      lps = 1'b0;
      enable = 1'b1;
      hold(1'b0, 10);
      hold(1'b1, h);
      hold(1'b0, l);
      flags(1'b0, 1'b0, req);
      lps = 1'b1;
      repeat (2) @(negedge clk);
      check(link_active, 1'b0, "R2", "link_active two edges after rise");
      @(negedge clk);
      check(link_active, 1'b1, "R2", "link_active three edges after rise");
      hold(1'b1, h - 3);
      hold(1'b0, l);
      flags(1'b1, 1'b0, req);
      turn_off();
   endtask

   task automatic t_short_high();
      enable = 1'b1;
      hold(1'b0, 10);
      hold(1'b1, 50);
      hold(1'b0, 50);
      hold(1'b1, 50);
      flags(1'b1, 1'b0, "R6");
      hold(1'b0, 50);
      hold(1'b1, MINC - 1);
      hold(1'b0, 10);
      flags(1'b0, 1'b1, "R6");
      hold(1'b0, 40);
      hold(1'b1, 50);
      hold(1'b0, 50);
      hold(1'b1, 8);
      flags(1'b1, 1'b0, "R9");
      turn_off();
   endtask

   task automatic t_short_low();
      enable = 1'b1;
      hold(1'b0, 10);
      hold(1'b1, 50);
      hold(1'b0, 50);
      hold(1'b1, 50);
      flags(1'b1, 1'b0, "R7");
      hold(1'b0, MINC - 1);
      hold(1'b1, 10);
      flags(1'b0, 1'b1, "R7");
      hold(1'b1, 40);
      hold(1'b0, 50);
      hold(1'b1, 8);
      flags(1'b1, 1'b0, "R9");
      turn_off();
   endtask

   task automatic t_partial_first();
      hold(1'b1, 5);
      enable = 1'b1;
      hold(1'b1, 3);
      hold(1'b0, 10);
      flags(1'b0, 1'b0, "R10");
      hold(1'b0, 40);
      hold(1'b1, 50);
      hold(1'b0, 50);
      hold(1'b1, 8);
      flags(1'b1, 1'b0, "R10");
      turn_off();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      flags(1'b0, 1'b0, "R1");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      flags(1'b0, 1'b0, "R1");
      t_steady_high();
      t_steady_low();
      t_train(50, 50, "R5");
      t_train(MINC, MINC, "R8");
      t_train(MAXC, MAXC, "R8");
      t_short_high();
      t_short_low();
      t_partial_first();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule